// File: doc/BRIEF.md
# Prescaler Chain with Watchdog

This block divides a base tick into a fifteen-stage binary chain of taps. Timers, key debounce and the display driver use these taps as rate enables. Every stage is a toggle flop. The whole chain runs in the single system clock domain. A one-cycle enable, `base_tick_i`, stands in for each falling edge of the base tap. A stage flips when the stage below it falls from high to low. The taps therefore read as a binary count, with stage s on bit s-1 of `taps_o`.

The upper stages, 11 to 15, can be cleared on their own by a strobe, and they also clear on pin reset. The lower stages keep counting through either event. A falling edge of stage 14 that comes from counting gives a one-cycle wake pulse, which is used to release a halted core.

A watchdog counts falling edges of stage 10 and fires a one-cycle reset pulse when its interval runs out. The interval is 8, 64 or 512 edges. It is built as a three-state machine:
- WD_OFF moves to WD_ARMED on the *arm* transition (`wd_set_i` without `wd_clr_i`).
- WD_ARMED moves to WD_FIRE on the *overflow* transition: a counted edge with the count at the limit and no kick.
- WD_FIRE moves back to WD_ARMED on the *rearm* transition, which is automatic one cycle later.
- Both active states go to WD_OFF on the *disarm* transition (`wd_clr_i`), on power-on reset and on pin reset.

The pulse the watchdog raises never clears its own enable.

Top module: `prescale_wdog`

## Requirements
- R1: Bit s-1 of `taps_o` is stage s. Each cycle with `base_tick_i` high adds one to the chain as a binary count. Stage 1 toggles on every tick, and stage s toggles when stage s-1 falls. With no tick, no clear and no reset, `taps_o` holds its value.
- R2: A cycle with `clr_hi_i` high forces stages 11 to 15 (`taps_o[14:10]`) to 0 at that edge. Stages 1 to 10 still take that cycle's tick.
- R3: `pin_rst_i` clears stages 11 to 15 the same way and leaves stages 1 to 10 counting. It also puts the watchdog in WD_OFF with a zero count, so no pulse follows until the watchdog is armed again.
- R4: `wake_o` is high for exactly one cycle, in the cycle after an edge at which counting takes stage 14 from 1 to 0. A clear or reset never raises it. With a tick every cycle, wake pulses are 16384 cycles apart.
- R5: `wd_sel_i` selects the interval in falling edges of the watchdog tap: 0 selects 8, 1 selects 64, and 2 or 3 select 512.
- R6: `wd_rst_o` is a single-cycle pulse, raised in the cycle after the edge on which the counted tap edge reaches the interval. The count restarts from zero at that edge.
- R7: `wd_set_i` arms and `wd_clr_i` disarms the watchdog; when both are high, disarm wins. While disarmed, the count stays at zero and `wd_rst_o` stays low.
- R8: The watchdog's own pulse leaves the enable set. Pulses repeat every interval until the watchdog is disarmed.
- R9: `wd_kick_i` clears the count. A kick on the same edge as an overflow suppresses that pulse.
- R10: While and after `por_i`, all taps are 0, the watchdog is disarmed, and `wd_rst_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | External reset pin, synchronous, active high |
| base_tick_i | input | 1 | One-cycle enable marking a falling edge of the base tap |
| clr_hi_i | input | 1 | Strobe that clears stages 11 to 15 |
| wd_set_i | input | 1 | Arm the watchdog |
| wd_clr_i | input | 1 | Disarm the watchdog |
| wd_kick_i | input | 1 | Restart the watchdog count |
| wd_sel_i | input | 2 | Watchdog interval select (0: 8, 1: 64, 2/3: 512) |
| taps_o | output | 15 | Prescaler stages, stage s on bit s-1 |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |
| wake_o | output | 1 | One-cycle wake pulse on a stage-14 falling edge |

## Verification
The bench builds the block with the watchdog tap moved from stage 10 down to stage 3 (`WD_TAP=3`), and keeps the 15 stages, the clear boundary at stage 11 and the wake tap at stage 14. With the tap at stage 3, all three intervals fit inside a short run: 64, 512 and 4096 cycles apart with a tick every cycle. The run can then cover repeated pulses after a self-caused reset, kick-versus-overflow races and disarm-versus-arm races. The wake tap stays at its real position, so the 16384-cycle spacing between wake pulses and the clears that hit stage 14 while it is high are exercised at their real sizes.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/presc_chain.sv
module presc_chain #(
    parameter int NSTAGE   = 15,
    parameter int CLR_LO   = 11,
    parameter int WAKE_TAP = 14,
    parameter int WD_TAP   = 10
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              pin_rst_i,
    input  logic              tick_i,
    input  logic              clr_hi_i,
    output logic [NSTAGE-1:0] taps_o,
    output logic              wake_o,
    output logic              wd_fall_o
);

    // carry[s] high: stage s (bit s-1) falls this edge, so bit s toggles
    logic [NSTAGE:0]   carry;
    logic [NSTAGE-1:0] stage_q;
    logic              hi_clear;
    logic              wake_q;

    assign carry[0] = tick_i;
    assign hi_clear = clr_hi_i | pin_rst_i;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        assign carry[s+1] = carry[s] & stage_q[s];

        if (s >= CLR_LO - 1) begin : g_upper
            always_ff @(posedge clk) begin
                if (por_i || hi_clear) begin
                    stage_q[s] <= 1'b0;
                end else if (carry[s]) begin
                    stage_q[s] <= ~stage_q[s];
                end
            end
        end else begin : g_lower
            always_ff @(posedge clk) begin
                if (por_i) begin
                    stage_q[s] <= 1'b0;
                end else if (carry[s]) begin
                    stage_q[s] <= ~stage_q[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= carry[WAKE_TAP] & ~hi_clear;
        end
    end

    assign taps_o    = stage_q;
    assign wake_o    = wake_q;
    assign wd_fall_o = carry[WD_TAP];

endmodule

// File: rtl/wd_fsm.sv
module wd_fsm
    import pwd_pkg::*;
#(
    parameter int EXP0 = 3,
    parameter int EXP1 = 6,
    parameter int EXP2 = 9
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       pin_rst_i,
    input  logic       fall_i,
    input  logic       set_i,
    input  logic       clr_i,
    input  logic       kick_i,
    input  logic [1:0] sel_i,
    output logic       rst_pulse_o
);

    localparam int CW = EXP2;
    localparam logic [CW-1:0] LIM0 = CW'((1 << EXP0) - 1);
    localparam logic [CW-1:0] LIM1 = CW'((1 << EXP1) - 1);
    localparam logic [CW-1:0] LIM2 = CW'((1 << EXP2) - 1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] last_val;
    logic          at_limit;

    always_comb begin
        unique case (sel_i)
            2'd0:    last_val = LIM0;
            2'd1:    last_val = LIM1;
            default: last_val = LIM2;
        endcase
    end

    assign at_limit = fall_i && (cnt_q >= last_val) && !kick_i;

    // state register
    always_ff @(posedge clk) begin
        if (por_i || pin_rst_i) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: arm, overflow, rearm, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (set_i && !clr_i) state_d = WD_ARMED;
            WD_ARMED: if (clr_i)           state_d = WD_OFF;
                      else if (at_limit)   state_d = WD_FIRE;
            WD_FIRE:  if (clr_i)           state_d = WD_OFF;
                      else                 state_d = WD_ARMED;
            default:                       state_d = WD_OFF;
        endcase
    end

    always_comb begin
        if (state_d == WD_OFF) begin
            cnt_d = '0;
        end else if (kick_i) begin
            cnt_d = '0;
        end else if (state_q == WD_ARMED && state_d == WD_FIRE) begin
            cnt_d = '0;
        end else if (state_q != WD_OFF && fall_i) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // outputs
    always_comb begin
        rst_pulse_o = (state_q == WD_FIRE);
    end

endmodule

// File: rtl/prescale_wdog.sv
module prescale_wdog #(
    parameter int NSTAGE   = 15,
    parameter int CLR_LO   = 11,
    parameter int WAKE_TAP = 14,
    parameter int WD_TAP   = 10,
    parameter int WD_EXP0  = 3,
    parameter int WD_EXP1  = 6,
    parameter int WD_EXP2  = 9
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              pin_rst_i,
    input  logic              base_tick_i,
    input  logic              clr_hi_i,
    input  logic              wd_set_i,
    input  logic              wd_clr_i,
    input  logic              wd_kick_i,
    input  logic [1:0]        wd_sel_i,
    output logic [NSTAGE-1:0] taps_o,
    output logic              wd_rst_o,
    output logic              wake_o
);

    logic wd_fall;

    presc_chain #(
        .NSTAGE  (NSTAGE),
        .CLR_LO  (CLR_LO),
        .WAKE_TAP(WAKE_TAP),
        .WD_TAP  (WD_TAP)
    ) u_chain (
        .clk      (clk),
        .por_i    (por_i),
        .pin_rst_i(pin_rst_i),
        .tick_i   (base_tick_i),
        .clr_hi_i (clr_hi_i),
        .taps_o   (taps_o),
        .wake_o   (wake_o),
        .wd_fall_o(wd_fall)
    );

    wd_fsm #(
        .EXP0(WD_EXP0),
        .EXP1(WD_EXP1),
        .EXP2(WD_EXP2)
    ) u_wd (
        .clk        (clk),
        .por_i      (por_i),
        .pin_rst_i  (pin_rst_i),
        .fall_i     (wd_fall),
        .set_i      (wd_set_i),
        .clr_i      (wd_clr_i),
        .kick_i     (wd_kick_i),
        .sel_i      (wd_sel_i),
        .rst_pulse_o(wd_rst_o)
    );

endmodule

// File: rtl/prescale_wdog_chk.sv
module prescale_wdog_chk #(
    parameter int NSTAGE = 15,
    parameter int CLR_LO = 11
) (
    input logic              clk,
    input logic              por_i,
    input logic              pin_rst_i,
    input logic              base_tick_i,
    input logic              clr_hi_i,
    input logic              wd_set_i,
    input logic              wd_clr_i,
    input logic              wd_kick_i,
    input logic [1:0]        wd_sel_i,
    input logic [NSTAGE-1:0] taps_o,
    input logic              wd_rst_o,
    input logic              wake_o
);

    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (por_i)
        (!base_tick_i && !clr_hi_i && !pin_rst_i) |=> $stable(taps_o)); // R1

    AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (por_i)
        (clr_hi_i || pin_rst_i) |=> (taps_o[NSTAGE-1:CLR_LO-1] == '0)); // R2

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (por_i)
        wake_o |=> !wake_o); // R4

    AST_NO_WAKE_ON_CLEAR: assert property (@(posedge clk) disable iff (por_i)
        (clr_hi_i || pin_rst_i) |=> !wake_o); // R4

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (por_i)
        wd_rst_o |=> !wd_rst_o); // R6

    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (por_i)
        (wd_clr_i || pin_rst_i) |=> !wd_rst_o); // R7

    AST_KICK_HOLDS: assert property (@(posedge clk) disable iff (por_i)
        wd_kick_i |=> !wd_rst_o); // R9

    AST_POR_STATE: assert property (@(posedge clk)
        por_i |=> (taps_o == '0 && !wd_rst_o && !wake_o)); // R10

endmodule

bind prescale_wdog prescale_wdog_chk #(
    .NSTAGE(NSTAGE),
    .CLR_LO(CLR_LO)
) u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .pin_rst_i  (pin_rst_i),
    .base_tick_i(base_tick_i),
    .clr_hi_i   (clr_hi_i),
    .wd_set_i   (wd_set_i),
    .wd_clr_i   (wd_clr_i),
    .wd_kick_i  (wd_kick_i),
    .wd_sel_i   (wd_sel_i),
    .taps_o     (taps_o),
    .wd_rst_o   (wd_rst_o),
    .wake_o     (wake_o)
);

// File: tb/prescale_wdog_tb.sv
module prescale_wdog_tb;

    localparam int TB_WD_TAP = 3;

    logic        clk = 1'b0;
    logic        por_i = 1'b1, pin_rst_i = 1'b0, base_tick_i = 1'b0, clr_hi_i = 1'b0;
    logic        wd_set_i = 1'b0, wd_clr_i = 1'b0, wd_kick_i = 1'b0;
    logic [1:0]  wd_sel_i = 2'd0;
    logic [14:0] taps_o;
    logic        wd_rst_o, wake_o;

    int n_vec = 0, n_bad = 0, n_cyc = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    prescale_wdog #(.WD_TAP(TB_WD_TAP)) u_dut (
        .clk(clk), .por_i(por_i), .pin_rst_i(pin_rst_i), .base_tick_i(base_tick_i),
        .clr_hi_i(clr_hi_i), .wd_set_i(wd_set_i), .wd_clr_i(wd_clr_i),
        .wd_kick_i(wd_kick_i), .wd_sel_i(wd_sel_i),
        .taps_o(taps_o), .wd_rst_o(wd_rst_o), .wake_o(wake_o)
    );

    function automatic int interval(input logic [1:0] sel);
        return (sel == 2'd0) ? 8 : (sel == 2'd1) ? 64 : 512;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    logic [14:0] m_cnt = '0;
    bit m_en = 0, m_fire = 0, m_wake = 0;
    int m_n = 0;

    always @(posedge clk) begin
        logic [14:0] inc;
        bit fall, fire_n;
        inc    = m_cnt + 15'(base_tick_i);
        fall   = base_tick_i && m_cnt[TB_WD_TAP-1] && !inc[TB_WD_TAP-1];
        m_wake = !por_i && !clr_hi_i && !pin_rst_i && base_tick_i && m_cnt[13] && !inc[13];
        if (por_i) m_cnt = '0;
        else begin
            if (clr_hi_i || pin_rst_i) inc[14:10] = '0;
            m_cnt = inc;
        end
        fire_n = 0;
        if (por_i || pin_rst_i) begin
            m_en = 0; m_n = 0;
        end else if (!m_en) begin
            m_n = 0;
            if (wd_set_i && !wd_clr_i) m_en = 1;
        end else if (wd_clr_i) begin
            m_en = 0; m_n = 0;
        end else if (wd_kick_i) begin
            m_n = 0;
        end else if (fall) begin
            if (!m_fire && m_n + 1 >= interval(wd_sel_i)) begin
                m_n = 0; fire_n = 1;
            end else m_n = m_n + 1;
        end
        m_fire = fire_n;
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            chk(taps_o == m_cnt, "R1", taps_o, m_cnt);
            chk(wake_o == m_wake, "R4", wake_o, m_wake);
            chk(wd_rst_o == m_fire, "R6", wd_rst_o, m_fire);
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set();
        wd_set_i = 1; cyc(1); wd_set_i = 0;
    endtask

    task automatic pulse_clr();
        wd_clr_i = 1; cyc(1); wd_clr_i = 0;
    endtask

    // cycles from one high sample of sig to the next
    task automatic gap(input bit use_wake, input int lim, output int len);
        int k = 0;
        while (!(use_wake ? wake_o : wd_rst_o) && k < lim) begin cyc(1); k++; end
        cyc(1); len = 1;
        while (!(use_wake ? wake_o : wd_rst_o) && len < lim) begin cyc(1); len++; end
    endtask

    int pulses;

    initial begin
        int len;
        logic [14:0] old;
        void'($urandom(32'd4711));
        cyc(3);
        // R10: reset state
        chk(taps_o == 0, "R10", taps_o, 0);
        chk(!wd_rst_o && !wake_o, "R10", {wd_rst_o, wake_o}, 0);
        por_i = 0;
        model_on = 1'b1;

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) wd_sel_i = 2'($urandom % 4);
            base_tick_i = ($urandom % 4) != 0;
            clr_hi_i    = ($urandom % 97) == 0;
            pin_rst_i   = ($urandom % 800) == 0;
            wd_set_i    = ($urandom % 40) == 0;
            wd_clr_i    = ($urandom % 400) == 0;
            wd_kick_i   = ($urandom % 150) == 0;
            cyc(1);
        end
        {clr_hi_i, pin_rst_i, wd_set_i, wd_clr_i, wd_kick_i} = '0;
        base_tick_i = 1;

        // R5 / R8: interval per select, repeated pulses keep firing
        for (int s = 0; s < 3; s++) begin
            pulse_clr();
            wd_sel_i = 2'(s);
            pulse_set();
            gap(1'b0, 20000, len);
            chk(len == interval(2'(s)) * 8, "R5", len, interval(2'(s)) * 8);
            gap(1'b0, 20000, len);
            chk(len == interval(2'(s)) * 8, "R8", len, interval(2'(s)) * 8);
        end

        // R9: periodic kicks keep the watchdog quiet
        wd_sel_i = 2'd0; pulses = 0;
        for (int i = 0; i < 1500; i++) begin
            wd_kick_i = (i % 40) == 0;
            cyc(1);
            if (wd_rst_o) pulses++;
        end
        wd_kick_i = 0;
        chk(pulses == 0, "R9", pulses, 0);

        // R7: disarm with a simultaneous arm stays off
        wd_set_i = 1; wd_clr_i = 1; cyc(1); wd_set_i = 0; wd_clr_i = 0;
        pulses = 0;
        for (int i = 0; i < 600; i++) begin cyc(1); if (wd_rst_o) pulses++; end
        chk(pulses == 0, "R7", pulses, 0);

        // R2: clear strobe leaves lower stages counting
        cyc(3000);
        old = taps_o;
        clr_hi_i = 1; cyc(1); clr_hi_i = 0;
        chk(taps_o[14:10] == 0, "R2", taps_o[14:10], 0);
        chk(taps_o[9:0] == 10'(old[9:0] + 1), "R2", taps_o[9:0], 10'(old[9:0] + 1));

        // R3: pin reset clears upper stages and disarms the watchdog
        pulse_set();
        cyc(3000);
        old = taps_o;
        pin_rst_i = 1; cyc(1); pin_rst_i = 0;
        chk(taps_o[14:10] == 0, "R3", taps_o[14:10], 0);
        chk(taps_o[9:0] == 10'(old[9:0] + 1), "R3", taps_o[9:0], 10'(old[9:0] + 1));
        pulses = 0;
        for (int i = 0; i < 600; i++) begin cyc(1); if (wd_rst_o) pulses++; end
        chk(pulses == 0, "R3", pulses, 0);

        // R4: wake spacing with a tick every cycle
        gap(1'b1, 40000, len);
        chk(len == 16384, "R4", len, 16384);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule